// File: doc/BRIEF.md
# Optical Link Monitor State Machine

This block decides whether an optical receive path is healthy enough to carry traffic. It looks at two things: a digital flag that says the received light level is above threshold, and the sliced receive data stream, which must keep toggling. The link counts as good only while the level flag is true and receive edges keep arriving no further apart than a set gap limit. When the link is good the block holds a pass state. When either condition fails it drops to a low-light state.

In low light the block switches off the enables for the transmit data path, the receive path and the loopback path. The transmitter's idle tone is produced elsewhere and is not gated here. It also drives a status flag that lets neighbouring logic suppress the collision self-test. To leave low light, the good condition has to hold without a break for a long qualification time. If the condition breaks during that time, the wait starts again from zero. After the wait, the block re-enables only in a cycle where neither transmit nor receive activity is present. An active-low LED output is lit while the link is in the pass state.

All delays are parameters counted in clock cycles. With a 100 MHz clock the defaults give a 3 µs transition gap and a 500 ms qualification time. A simulation can shorten both.

Top module: `optical_link_monitor`

## Requirements
- R1: While reset is held and after it is released, the block is in low light: `link_led_n`=1, `low_light`=1, and `tx_en`, `rx_en`, `loop_en` are all 0.
- R2: In the pass state, a clock edge that samples `level_ok`=0 moves the block to low light, and the outputs show this after that same edge.
- R3: The transition gap counter restarts on every change of `rx_data`. Once GAP_CYCLES clock edges in a row have sampled no change, receive activity counts as lost and the pass state falls to low light on the next edge. Edges spaced exactly GAP_CYCLES cycles apart keep the link up.
- R4: `tx_en`, `rx_en` and `loop_en` are 1 exactly when the block is in the pass state. `low_light` is their inverse. `link_led_n` is 0 (lit) exactly in the pass state.
- R5: From low light, the block enters pass only after QUAL_CYCLES consecutive edges that each sampled the good condition. Good means `level_ok`=1 and receive activity present.
- R6: If the good condition is missing at any edge during qualification, the qualification count restarts from zero.
- R7: Once qualification is complete, the move to pass waits while `tx_active` or `rx_active` is 1. It happens at the first edge where both are 0 and the signal is still good.
- R8: In the pass state, `tx_active` and `rx_active` have no effect: the link stays up while the signal is good.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| level_ok | input | 1 | Received optical level is above threshold |
| rx_data | input | 1 | Sliced receive data, already synchronous to clk |
| tx_active | input | 1 | Transmit input from the station is not idle |
| rx_active | input | 1 | Receive data is being delivered |
| link_led_n | output | 1 | Link LED drive, low = lit (pass state) |
| tx_en | output | 1 | Enable for the transmit data path |
| rx_en | output | 1 | Enable for the receive path |
| loop_en | output | 1 | Enable for the loopback path |
| low_light | output | 1 | Low-light status, used to suppress the collision self-test |

## Verification
The hardest case to reach from the ports is a qualification that has fully completed while the line is still busy. The block has to hold in low light with the count saturated, then switch over at the exact edge where activity stops. The stimulus holds `tx_active` high through a full qualification time and beyond. It then drops `tx_active` while `rx_active` is high, and only then makes the line quiet. Other stimulus toggles `rx_data` at a spacing of exactly GAP_CYCLES and then GAP_CYCLES+1 cycles, which exercises the edge of the gap limit. It also breaks `level_ok` for one cycle in the middle of a qualification to force the restart.

// File: rtl/olm_pkg.sv
// Package: types shared by the optical link monitor modules.
// Assumes nothing beyond a two-state link decision.
package olm_pkg;

    typedef enum logic {
        LINK_LOW  = 1'b0,
        LINK_PASS = 1'b1
    } link_state_e;

endpackage

// File: rtl/olm_gap_timer.sv
// Transition gap timer.
// Registers the sliced receive data and detects each change. A counter
// restarts on every change and saturates at GAP_CYCLES. Activity counts
// as present while the counter is below the limit.
// Assumes rx_data is already synchronous to clk.
module olm_gap_timer #(
    parameter int GAP_CYCLES = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_data,
    output logic activity_ok
);
    localparam int GW = $clog2(GAP_CYCLES + 1);
    localparam logic [GW-1:0] GAP_MAX = GW'(GAP_CYCLES);

    logic          rx_q;
    logic [GW-1:0] gap_cnt;
    logic          edge_seen;

    // Change detect between the current and the previous sample.
    assign edge_seen = rx_data ^ rx_q;

    // Remember the previous receive sample.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_q <= 1'b0;
        else        rx_q <= rx_data;
    end

    // Count idle cycles since the last edge, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                gap_cnt <= GAP_MAX;
        else if (edge_seen)        gap_cnt <= '0;
        else if (gap_cnt < GAP_MAX) gap_cnt <= gap_cnt + 1'b1;
    end

    // Activity is present while the gap is below the limit.
    assign activity_ok = (gap_cnt < GAP_MAX);

    AST_EDGE_REVIVES: assert property (@(posedge clk) disable iff (!rst_n)
        edge_seen |=> activity_ok) else $error("edge did not restore activity"); // R3
    AST_LOST_STAYS_LOST: assert property (@(posedge clk) disable iff (!rst_n)
        (!activity_ok && !edge_seen) |=> !activity_ok) else $error("activity returned without an edge"); // R3

endmodule

// File: rtl/olm_qual_timer.sv
// Qualification timer.
// Counts consecutive good cycles while the link is down and saturates at
// QUAL_CYCLES. Any bad cycle restarts the count. The count is held at
// zero while the link is up.
// Assumes good is sampled on every clock edge.
module olm_qual_timer #(
    parameter int QUAL_CYCLES = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic good,
    output logic qual_done
);
    localparam int QW = $clog2(QUAL_CYCLES + 1);
    localparam logic [QW-1:0] QUAL_MAX = QW'(QUAL_CYCLES);

    logic [QW-1:0] qual_cnt;

    // Count uninterrupted good cycles, restarting on any break.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !good) qual_cnt <= '0;
        else if (qual_cnt < QUAL_MAX)  qual_cnt <= qual_cnt + 1'b1;
    end

    // Qualification is complete once the count has saturated.
    assign qual_done = (qual_cnt == QUAL_MAX);

    AST_QUAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (qual_done && good && !clear) |=> qual_done) else $error("qualification lost while good"); // R5

endmodule

// File: rtl/olm_link_fsm.sv
// Link state machine.
// Leaves pass when the signal goes bad. Enters pass from low light only
// once qualification is done, the signal is still good and the line is
// quiet in both directions.
// Assumes its inputs are synchronous to clk.
module olm_link_fsm
    import olm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic signal_good,
    input  logic qual_done,
    input  logic tx_active,
    input  logic rx_active,
    output logic link_up
);
    link_state_e state_q, state_d;

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINK_PASS: if (!signal_good) state_d = LINK_LOW;
            LINK_LOW:  if (qual_done && signal_good && !tx_active && !rx_active)
                           state_d = LINK_PASS;
            default:   state_d = LINK_LOW;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LINK_LOW;
        else        state_q <= state_d;
    end

    assign link_up = (state_q == LINK_PASS);

    AST_DROP_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && !signal_good) |=> !link_up) else $error("link stayed up on bad signal"); // R2
    AST_ENTRY_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_up && !qual_done) |=> !link_up) else $error("link up without qualification"); // R5
    AST_RESTART_ON_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_up && !signal_good) |=> !qual_done) else $error("qualification survived a break"); // R6
    AST_WAIT_FOR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_up && (tx_active || rx_active)) |=> !link_up) else $error("link up on busy line"); // R7
    AST_PASS_IGNORES_ACTIVITY: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && signal_good) |=> link_up) else $error("link dropped while good"); // R8

endmodule

// File: rtl/optical_link_monitor.sv
// Optical link monitor top.
// Combines the transition gap timer, the qualification timer and the link
// state machine, and drives the path enables, the low-light flag and the
// active-low LED from the link state.
// Assumes level_ok and rx_data are digital and synchronous to clk.
module optical_link_monitor #(
    parameter int GAP_CYCLES  = 300,
    parameter int QUAL_CYCLES = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_ok,
    input  logic rx_data,
    input  logic tx_active,
    input  logic rx_active,
    output logic link_led_n,
    output logic tx_en,
    output logic rx_en,
    output logic loop_en,
    output logic low_light
);
    logic activity_ok;
    logic signal_good;
    logic qual_done;
    logic link_up;

    olm_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_data     (rx_data),
        .activity_ok (activity_ok)
    );

    // Good means adequate level together with recent transitions.
    assign signal_good = level_ok && activity_ok;

    olm_qual_timer #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (link_up),
        .good      (signal_good),
        .qual_done (qual_done)
    );

    olm_link_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .signal_good (signal_good),
        .qual_done   (qual_done),
        .tx_active   (tx_active),
        .rx_active   (rx_active),
        .link_up     (link_up)
    );

    // Output drive from the link state.
    assign tx_en      = link_up;
    assign rx_en      = link_up;
    assign loop_en    = link_up;
    assign low_light  = !link_up;
    assign link_led_n = !link_up;

    AST_LOSS_OF_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_led_n && !level_ok) |=> link_led_n) else $error("LED lit after level loss"); // R2
    AST_ENABLES_TRACK_LED: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en == !link_led_n) && (rx_en == tx_en) && (loop_en == tx_en)) else $error("outputs disagree"); // R4

endmodule

// File: tb/optical_link_monitor_tb.sv
module optical_link_monitor_tb;
    localparam int G = 8;
    localparam int Q = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic level_ok = 1'b0, rx_data = 1'b0, tx_active = 1'b0, rx_active = 1'b0;
    logic link_led_n, tx_en, rx_en, loop_en, low_light;

    int tests = 0, fails = 0, cyc = 0;
    int tog_per = 0;
    string phase = "R1 reset";
    bit done = 0;

    // Reference model state
    int m_gap = G, m_qual = 0;
    bit m_prev = 0, m_pass = 0;
    bit m_act, m_good, m_np;

    always #5 clk = ~clk;

    optical_link_monitor #(.GAP_CYCLES(G), .QUAL_CYCLES(Q)) u_dut (
        .clk(clk), .rst_n(rst_n), .level_ok(level_ok), .rx_data(rx_data),
        .tx_active(tx_active), .rx_active(rx_active), .link_led_n(link_led_n),
        .tx_en(tx_en), .rx_en(rx_en), .loop_en(loop_en), .low_light(low_light)
    );

    // Behavioural reference model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_prev = 0; m_gap = G; m_qual = 0; m_pass = 0;
        end else begin
            m_act  = (m_gap < G);
            m_good = level_ok && m_act;
            if (m_pass) m_np = m_good;
            else        m_np = (m_qual == Q) && m_good && !tx_active && !rx_active;
            if (m_pass || !m_good) m_qual = 0;
            else if (m_qual < Q)   m_qual = m_qual + 1;
            if (rx_data != m_prev) m_gap = 0;
            else if (m_gap < G)    m_gap = m_gap + 1;
            m_prev = rx_data;
            m_pass = m_np;
        end
    end

    // Compare every cycle away from the active edge, then drive the receive toggle
    always @(negedge clk) begin
        if (!done) begin
            tests++;
            if ({link_led_n, tx_en, rx_en, loop_en, low_light} !==
                {!m_pass, m_pass, m_pass, m_pass, !m_pass}) begin
                fails++;
                $display("FAIL %s cycle %0d: actual led_n=%b tx=%b rx=%b loop=%b low=%b expected pass=%b",
                         phase, cyc, link_led_n, tx_en, rx_en, loop_en, low_light, m_pass);
            end
        end
        cyc++;
        if (tog_per > 0 && (cyc % tog_per) == 0) rx_data = ~rx_data;
    end

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic expect_link(input bit up, input string tag);
        tests++;
        if (link_led_n !== !up || low_light !== !up) begin
            fails++;
            $display("FAIL %s: actual led_n=%b low=%b expected led_n=%b", tag, link_led_n, low_light, !up);
        end
    endtask

    task automatic finish_run;
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Watchdog
    initial begin
        #(10 * 20000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        wait_cycles(3);
        expect_link(0, "R1 during reset");
        rst_n = 1'b1;
        wait_cycles(2);
        expect_link(0, "R1 after reset");

        // R5: good signal, qualify and enter pass
        phase = "R5 qualify";
        level_ok = 1'b1; tog_per = 2;
        wait_cycles(Q - 5);
        expect_link(0, "R5 before qualification ends");
        wait_cycles(15);
        expect_link(1, "R5 pass after qualification");
        tests++;
        if (tx_en !== 1 || rx_en !== 1 || loop_en !== 1) begin
            fails++; $display("FAIL R4: enables %b%b%b expected 111", tx_en, rx_en, loop_en);
        end

        // R8: activity ignored in pass
        phase = "R8 activity in pass";
        tx_active = 1; rx_active = 1;
        wait_cycles(10);
        expect_link(1, "R8 stays up with activity");
        tx_active = 0; rx_active = 0;

        // R2: single-cycle level loss
        phase = "R2 level loss";
        level_ok = 0;
        wait_cycles(1);
        expect_link(0, "R2 drop after one edge");
        tests++;
        if (tx_en !== 0 || rx_en !== 0 || loop_en !== 0) begin
            fails++; $display("FAIL R4: enables %b%b%b expected 000", tx_en, rx_en, loop_en);
        end
        level_ok = 1;

        // R6: break in the middle of qualification restarts the count
        phase = "R6 restart";
        wait_cycles(Q / 2);
        level_ok = 0;
        wait_cycles(1);
        level_ok = 1;
        wait_cycles(Q / 2 + 5);
        expect_link(0, "R6 not up after uninterrupted total");
        wait_cycles(Q);
        expect_link(1, "R6 up after full restart");

        // R3: spacing exactly G keeps link, G+1 loses it
        phase = "R3 gap boundary";
        tog_per = G;
        wait_cycles(6 * G);
        expect_link(1, "R3 spacing at limit");
        tog_per = G + 1;
        wait_cycles(3 * G);
        expect_link(0, "R3 spacing past limit");

        // R7: qualification done but line busy
        phase = "R7 quiet wait";
        tog_per = 2; tx_active = 1;
        wait_cycles(Q + 20);
        expect_link(0, "R7 held by tx_active");
        rx_active = 1; tx_active = 0;
        wait_cycles(10);
        expect_link(0, "R7 held by rx_active");
        rx_active = 0;
        wait_cycles(1);
        expect_link(1, "R7 up on first quiet edge");

        // R3: transitions stop entirely
        phase = "R3 no transitions";
        tog_per = 0;
        wait_cycles(G + 3);
        expect_link(0, "R3 link lost without edges");

        wait_cycles(2);
        finish_run();
    end
endmodule